// File: doc/BRIEF.md
# Self-Recovering Cascadable BCD Decade Counter

This block is a chain of four-bit decimal digit counters built for numeric displays such as a clock readout. Each digit steps 0 to 9 and back to 0, advancing only on a rising clock edge in a cycle where its count enable is high. The wrap from 9 to 0 is made by the next-state logic on the same edge. No asynchronous clear is used, so the outputs never show a momentary ten.

A digit can hold one of the six codes above nine, for example after power-up. Such a code is replaced by zero on the next counted edge, with no detour through other values. Each digit drives a combinational carry while it sits at nine and is being counted. The next digit counts in that cycle only when its own enable is also high. A test load input lets a bench or scan sequence place any code, legal or not, into every digit.

Top module: `bcd_decade_chain`

## Requirements
- R1: While rst_n is low at a rising edge, every digit becomes 0000 and no carry is asserted in the following cycle.
- R2: A counted digit holding a value from 0 to 8 holds that value plus one after the edge.
- R3: A counted digit holding 1001 holds 0000 after the edge, and no other code appears between the two.
- R4: A counted digit holding any code from 1010 to 1111 holds 0000 after the edge.
- R5: A digit whose count enable is low keeps its value across the edge, and this includes codes from 1010 to 1111.
- R6: carry[i] is high in exactly the cycles where digit i holds 1001 and is being counted. It is a combinational output, so it rises in the cycle before the wrap edge.
- R7: Digit 0 is counted when count_en and digit_en[0] are both high. Digit i above 0 is counted when carry[i-1] and digit_en[i] are both high.
- R8: When tst_load is high at an edge (and rst_n is high), digit i takes tst_value[4i+3:4i]. This takes priority over counting.
- R9: Reset takes priority over tst_load.
- R10: carry is never high while its digit holds a code from 1010 to 1111.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| count_en | input | 1 | Count request into the lowest digit |
| digit_en | input | NUM_DIGITS | Per-digit count enable |
| tst_load | input | 1 | Test load strobe |
| tst_value | input | 4*NUM_DIGITS | Codes to load, digit i in bits 4i+3:4i |
| digits | output | 4*NUM_DIGITS | Digit values, digit i in bits 4i+3:4i |
| carry | output | NUM_DIGITS | Per-digit rollover carry |

## Verification
The in-line assertions check on every cycle that each digit steps, wraps, recovers or holds correctly. They also check that a carry is always followed by a zero digit, that no carry appears on an illegal code, that a load lands, and that a higher digit stays still while its lower neighbour gives no carry. What the assertions cannot show is full agreement with an independent model across whole scenarios. Only the bench scenarios cover that: counting through a two-digit rollover from 99 to 00, every illegal code being loaded, held and then recovered, a disabled upper digit while the lower one wraps, and reset overriding a load.

// File: rtl/bcd_pkg.sv
// Shared types and constants for the decade counter chain.
// Assumes: one decimal digit is coded in four binary bits.
package bcd_pkg;
    localparam int BCD_W = 4;
    typedef logic [BCD_W-1:0] bcd_t;
    localparam bcd_t BCD_TOP = bcd_t'(9);
endpackage

// File: rtl/bcd_next_state.sv
// Next-state logic of one decimal digit: value + 1 for 0..8, and zero for 9
// and for every code above 9, so illegal codes recover in one counted edge.
// Assumes: purely combinational, used by bcd_digit.
module bcd_next_state
    import bcd_pkg::*;
(
    input  bcd_t cur,
    output bcd_t nxt,
    output logic at_top
);
    // Pick the successor code and flag the top decimal value.
    always_comb begin
        at_top = (cur == BCD_TOP);
        if (cur >= BCD_TOP) begin
            nxt = '0;
        end else begin
            nxt = cur + bcd_t'(1);
        end
    end
endmodule

// File: rtl/bcd_digit.sv
// One decimal digit register with synchronous reset, test load and count.
// Priority: reset, then load, then count, otherwise hold. Carry is
// combinational: high while the digit sits at 9 and is being counted.
// Assumes: count_in already includes the digit's own enable.
module bcd_digit
    import bcd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic count_in,
    input  logic load,
    input  bcd_t load_val,
    output bcd_t q,
    output logic carry
);
    bcd_t nxt;
    logic at_top;

    bcd_next_state u_ns (
        .cur    (q),
        .nxt    (nxt),
        .at_top (at_top)
    );

    // Digit state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= load_val;
        end else if (count_in) begin
            q <= nxt;
        end
    end

    // Rollover flag for the next digit.
    assign carry = at_top & count_in;

    // R2: legal values below 9 advance by one.
    a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
        (count_in && !load && q < BCD_TOP) |=> (q == $past(q) + bcd_t'(1)));
    // R3: 9 wraps straight to 0.
    a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (count_in && !load && q == BCD_TOP) |=> (q == '0));
    // R4: illegal codes recover to 0.
    a_r4_recover: assert property (@(posedge clk) disable iff (!rst_n)
        (count_in && !load && q > BCD_TOP) |=> (q == '0));
    // R5: no count, no load, no change.
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!count_in && !load) |=> $stable(q));
    // R6: a carry is always followed by a zero digit.
    a_r6_carry_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (carry && !load) |=> (q == '0));
    // R8: load lands the requested code.
    a_r8_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (q == $past(load_val)));
    // R10: no carry on an illegal code.
    a_r10_no_bad_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (q > BCD_TOP) |-> !carry);
endmodule

// File: rtl/bcd_decade_chain.sv
// Chain of NUM_DIGITS decimal digits. Digit 0 counts on count_en and its own
// enable; each higher digit counts on the carry of the digit below and its
// own enable. tst_load preloads all digits (test hook).
// Assumes: single clock domain, synchronous active-low reset.
module bcd_decade_chain
    import bcd_pkg::*;
#(
    parameter int NUM_DIGITS = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        count_en,
    input  logic [NUM_DIGITS-1:0]       digit_en,
    input  logic                        tst_load,
    input  logic [BCD_W*NUM_DIGITS-1:0] tst_value,
    output logic [BCD_W*NUM_DIGITS-1:0] digits,
    output logic [NUM_DIGITS-1:0]       carry
);
    logic [NUM_DIGITS-1:0] link;
    logic [NUM_DIGITS-1:0] cnt;

    for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_dig
        bcd_t q_i;

        // Count request entering this digit.
        if (i == 0) begin : g_first
            assign link[i] = count_en;
        end else begin : g_rest
            assign link[i] = carry[i-1];
        end

        assign cnt[i] = link[i] & digit_en[i];

        bcd_digit u_dig (
            .clk      (clk),
            .rst_n    (rst_n),
            .count_in (cnt[i]),
            .load     (tst_load),
            .load_val (tst_value[BCD_W*i +: BCD_W]),
            .q        (q_i),
            .carry    (carry[i])
        );

        assign digits[BCD_W*i +: BCD_W] = q_i;

        // R7: a higher digit stays still while the lower gives no carry.
        if (i > 0) begin : g_chk
            a_r7_chain_hold: assert property (@(posedge clk) disable iff (!rst_n)
                (!carry[i-1] && !tst_load) |=> $stable(q_i));
        end
    end
endmodule

// File: tb/sim_bcd_decade_chain.sv
`timescale 1ns/1ps
module sim_bcd_decade_chain;
    localparam int N = 2;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           count_en;
    logic [N-1:0]   digit_en;
    logic           tst_load;
    logic [4*N-1:0] tst_value;
    logic [4*N-1:0] digits;
    logic [N-1:0]   carry;

    always #2.5 clk = ~clk;

    bcd_decade_chain #(.NUM_DIGITS(N)) u0 (
        .clk(clk), .rst_n(rst_n), .count_en(count_en), .digit_en(digit_en),
        .tst_load(tst_load), .tst_value(tst_value),
        .digits(digits), .carry(carry)
    );

    typedef struct {
        logic [4*N-1:0] exp_d;
        logic [N-1:0]   exp_c;
        string          tag;
    } item_t;

    item_t sb[$];
    int    compared = 0;
    int    mismatched = 0;
    int    model [N];
    bit    done = 0;

    // Driver: drive one cycle of inputs, push the expected outputs for this
    // cycle, then advance the reference model across the coming edge.
    task automatic step(input logic rn, input logic ce, input logic [N-1:0] de,
                        input logic ld, input logic [4*N-1:0] lv, input string tag);
        item_t it;
        logic [N-1:0] cn;
        logic lk;
        @(negedge clk);
        rst_n = rn; count_en = ce; digit_en = de; tst_load = ld; tst_value = lv;
        lk = ce;
        for (int i = 0; i < N; i++) begin
            cn[i] = lk & de[i];
            it.exp_c[i] = cn[i] && (model[i] == 9);
            it.exp_d[4*i +: 4] = 4'(model[i]);
            lk = it.exp_c[i];
        end
        it.tag = tag;
        sb.push_back(it);
        for (int i = 0; i < N; i++) begin
            if (!rn)        model[i] = 0;
            else if (ld)    model[i] = int'(lv[4*i +: 4]);
            else if (cn[i]) model[i] = (model[i] >= 9) ? 0 : model[i] + 1;
        end
    endtask

    // Monitor: just before each rising edge, compare outputs with the queue.
    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            #1.5;
            if (sb.size() > 0) begin
                it = sb.pop_front();
                compared++;
                if (digits !== it.exp_d || carry !== it.exp_c) begin
                    mismatched++;
                    $display("FAIL %s: digits=%h carry=%b expected digits=%h carry=%b",
                             it.tag, digits, carry, it.exp_d, it.exp_c);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #(5.0 * 20000);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; count_en = 1'b0; digit_en = '0; tst_load = 1'b0; tst_value = '0;
        for (int i = 0; i < N; i++) model[i] = 0;
        repeat (2) @(posedge clk);

        step(1, 0, 2'b11, 0, 8'h00, "R1 reset state");
        // Count 0..9, wrap, carry into digit 1 (cascade).
        for (int k = 0; k < 12; k++) step(1, 1, 2'b11, 0, 8'h00, "R2 R3 R6 R7 counting");
        // Hold with count low.
        for (int k = 0; k < 3; k++) step(1, 0, 2'b11, 0, 8'h00, "R5 hold");
        // Upper digit disabled while lower wraps.
        step(1, 0, 2'b11, 1, 8'h38, "R8 load 38");
        for (int k = 0; k < 4; k++) step(1, 1, 2'b01, 0, 8'h00, "R7 upper disabled");
        // Carry suppressed when count is off at 9.
        step(1, 0, 2'b11, 1, 8'h99, "R8 load 99");
        step(1, 0, 2'b11, 0, 8'h00, "R6 no carry without count");
        // Two-digit rollover 99 -> 00.
        step(1, 1, 2'b11, 0, 8'h00, "R6 R3 rollover 99");
        step(1, 0, 2'b11, 0, 8'h00, "R3 after rollover");
        // Each illegal code: load, hold, recover.
        for (int c = 10; c < 16; c++) begin
            step(1, 0, 2'b11, 1, {4'(c), 4'(c)}, "R8 load illegal");
            step(1, 0, 2'b11, 0, 8'h00, "R5 R10 illegal held");
            step(1, 1, 2'b11, 0, 8'h00, "R4 R10 illegal counted");
            step(1, 0, 2'b11, 0, 8'h00, "R4 recovered to zero");
        end
        // Load wins over counting.
        step(1, 1, 2'b11, 1, 8'h57, "R8 load over count");
        step(1, 0, 2'b11, 0, 8'h00, "R8 load value");
        // Reset wins over load.
        step(0, 1, 2'b11, 1, 8'h44, "R9 reset over load");
        step(1, 0, 2'b11, 0, 8'h00, "R1 R9 after reset");
        step(1, 0, 2'b11, 0, 8'h00, "R5 idle");

        repeat (3) @(posedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule